// File: doc/BRIEF.md
# RMII 10 Mbps Frame Transmitter

This block sends Ethernet frames over a two-bit reduced media-independent transmit interface at 10 Mbps. It runs on the 50 MHz reference clock, so each two-bit symbol (dibit) stays on the line for a fixed number of reference cycles. Frame bytes come from a byte-wide valid/ready stream with a last-byte marker. The block generates the preamble and start-of-frame delimiter itself. It pads short frames with zero bytes, appends a CRC-32 frame check sequence, and holds the line idle for the inter-frame gap before it starts the next frame.

A frame begins when the source raises `in_valid` while the transmitter is free. The first byte stays presented on the stream while the preamble goes out. The stream then sees back-pressure: `in_ready` is a single-cycle pulse at the end of the dibit that comes before each data byte. A byte moves in the cycle where `in_valid` and `in_ready` are both high. `in_ready` is low in these places:
- during the preamble, except for the closing cycle of the delimiter;
- during padding and the check sequence;
- during the gap;
- while idle.

The source must hold `in_valid` high from the first byte to the last byte. If `in_valid` is low in a cycle where `in_ready` is high, the frame is cut off. The same happens if a frame grows past the maximum size.

Top module: `rmii_tx_10m`

## Requirements
- R1: After reset, and whenever no frame is being sent, `tx_en` is 0, `txd` is 00, `in_ready` is 0 and both error outputs are 0. A transmitter with `in_valid` low never starts a frame.
- R2: A frame starts with `PRE_DIBITS` (31) dibits of 01 and then one dibit of 11. `tx_en` rises in the same cycle as the first 01 dibit, one cycle after `in_valid` is seen high by a free transmitter.
- R3: Every dibit, and the `tx_en` level, is held for exactly `CYC_PER_DIBIT` reference cycles. `txd` and `tx_en` change only at dibit boundaries.
- R4: Each data byte is sent as four dibits, least significant first: bits [1:0], then [3:2], then [5:4], then [7:6].
- R5: If the source delivers fewer than `MIN_BYTES` (60) bytes, zero bytes follow the data until `MIN_BYTES` bytes have been sent.
- R6: After data and padding come four check bytes, least significant byte first. They are the CRC-32 of data plus padding: reflected polynomial 0xEDB88320, start value 0xFFFFFFFF, result inverted.
- R7: `tx_en` falls in the cycle right after the last check-sequence dibit ends. A normal frame of n data bytes lasts exactly 32 + 4*(max(n, MIN_BYTES) + 4) dibits.
- R8: After `tx_en` falls, it stays low for at least `GAP_CYCLES` cycles. A source already waiting with `in_valid` high sees `tx_en` rise after exactly `GAP_CYCLES` low cycles.
- R9: `in_ready` is high for one cycle for each byte requested. It is high only in the last cycle of the delimiter or of a data byte's final dibit, never while `tx_en` is low, and never during padding or the check sequence.
- R10: If `in_ready` is high while `in_valid` is low, `err_underrun` pulses for one cycle, `tx_en` falls in that same cycle, no check sequence is sent, and the gap of R8 follows.
- R11: When `MAX_BYTES`-4 data bytes have been sent without a last marker, no further byte is requested. `err_oversize` pulses for one cycle, `tx_en` falls in that same cycle, and the gap of R8 follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Frame byte offered by the source |
| in_valid | input | 1 | Source offers a byte; high in idle requests a new frame |
| in_last | input | 1 | Offered byte is the final data byte of the frame |
| in_ready | output | 1 | One-cycle request; the byte transfers when in_valid is also high |
| txd | output | 2 | Transmit dibit |
| tx_en | output | 1 | Transmit enable |
| err_underrun | output | 1 | One-cycle pulse: source failed to supply a requested byte |
| err_oversize | output | 1 | One-cycle pulse: frame reached the size limit without a last byte |

## Verification
The bench builds the block with `CYC_PER_DIBIT` = 3, `GAP_CYCLES` = 40 and `MAX_BYTES` = 70, and keeps the 60-byte minimum and the 31-dibit preamble. With these values a frame never exceeds 312 dibits. The size limit falls only six bytes above the padding threshold, so frames just under the threshold, exactly at it, just over it and at the limit, as well as an oversize cut-off, all fit in a short run. The three-cycle hold is still long enough to show that dibits change only at symbol boundaries and that the gap holds back a source that is already waiting.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_DATA,
    S_PAD,
    S_FCS,
    S_GAP
  } tx_state_t;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  // Four reflected CRC steps for one nibble.
  function automatic logic [31:0] crc32_nibble(input logic [31:0] c, input logic [3:0] nib);
    logic [31:0] r;
    r = c ^ {28'd0, nib};
    for (int k = 0; k < 4; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  // Byte update: low nibble first, then high nibble.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    return crc32_nibble(crc32_nibble(c, b[3:0]), b[7:4]);
  endfunction

endpackage

// File: rtl/rmii_tx_timer.sv
module rmii_tx_timer #(
  parameter int CYC_PER_DIBIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CW = (CYC_PER_DIBIT > 2) ? $clog2(CYC_PER_DIBIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_DIBIT - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/rmii_tx_crc.sv
module rmii_tx_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  import rmii_tx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || init) crc <= 32'hFFFF_FFFF;
    else if (upd) crc <= crc32_byte(crc, data);
  end
endmodule

// File: rtl/rmii_tx_gap.sv
module rmii_tx_gap #(
  parameter int GAP_CYCLES = 480
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic done
);
  localparam int GW = $clog2(GAP_CYCLES);
  localparam logic [GW-1:0] LIM = GW'(GAP_CYCLES - 1);

  logic [GW-1:0] cnt;

  assign done = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= LIM;
    else if (clear) cnt <= '0;
    else if (!done) cnt <= cnt + GW'(1);
  end
endmodule

// File: rtl/rmii_tx_10m.sv
module rmii_tx_10m #(
  parameter int CYC_PER_DIBIT = 10,
  parameter int PRE_DIBITS    = 31,
  parameter int MIN_BYTES     = 60,
  parameter int MAX_BYTES     = 1522,
  parameter int GAP_CYCLES    = 480
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       err_underrun,
  output logic       err_oversize
);
  import rmii_tx_pkg::*;

  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam int PCW = $clog2(PRE_DIBITS + 1);
  localparam logic [BCW-1:0] MAX_DATA_C = BCW'(MAX_BYTES - 4);
  localparam logic [BCW-1:0] MIN_C      = BCW'(MIN_BYTES);
  localparam logic [PCW-1:0] SFD_IDX    = PCW'(PRE_DIBITS);

  tx_state_t      state;
  logic [PCW-1:0] pcnt;
  logic [1:0]     di;
  logic [7:0]     sh;
  logic [BCW-1:0] bcnt;
  logic           last_q;
  logic [23:0]    fcs_rest;
  logic [1:0]     fb;

  logic        tick, gap_done;
  logic [31:0] crc_q, fcs_word;
  logic        at_sfd_end, byte_done, more_data, need_byte, take;
  logic        underrun, oversize, tail_next, pad_next, fcs_done, finish, start;
  logic        crc_upd;
  logic [7:0]  crc_byte;

  always_comb begin
    at_sfd_end = (state == S_PRE) && (pcnt == SFD_IDX);
    byte_done  = (di == 2'd3);
    more_data  = (state == S_DATA) && byte_done && !last_q;
    need_byte  = tick && (at_sfd_end || (more_data && bcnt != MAX_DATA_C));
    take       = need_byte && in_valid;
    underrun   = need_byte && !in_valid;
    oversize   = tick && more_data && (bcnt == MAX_DATA_C);
    tail_next  = tick && byte_done && (((state == S_DATA) && last_q) || (state == S_PAD));
    pad_next   = tail_next && (bcnt < MIN_C);
    fcs_done   = tick && (state == S_FCS) && byte_done && (fb == 2'd3);
    finish     = underrun || oversize || fcs_done;
    start      = in_valid && ((state == S_IDLE) || ((state == S_GAP) && gap_done));
    crc_upd    = take || pad_next;
    crc_byte   = take ? in_data : 8'h00;
    fcs_word   = ~crc_q;
  end

  assign in_ready = need_byte;

  rmii_tx_timer #(.CYC_PER_DIBIT(CYC_PER_DIBIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(tx_en), .tick(tick)
  );

  rmii_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(start), .upd(crc_upd), .data(crc_byte), .crc(crc_q)
  );

  rmii_tx_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(finish), .done(gap_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      pcnt         <= '0;
      di           <= '0;
      sh           <= '0;
      bcnt         <= '0;
      last_q       <= 1'b0;
      fcs_rest     <= '0;
      fb           <= '0;
      txd          <= 2'b00;
      tx_en        <= 1'b0;
      err_underrun <= 1'b0;
      err_oversize <= 1'b0;
    end else begin
      err_underrun <= underrun;
      err_oversize <= oversize;
      if (start) begin
        state <= S_PRE;
        pcnt  <= '0;
        tx_en <= 1'b1;
        txd   <= 2'b01;
      end else if (finish) begin
        state <= S_GAP;
        tx_en <= 1'b0;
        txd   <= 2'b00;
      end else if (tick) begin
        unique case (state)
          S_PRE: begin
            if (at_sfd_end) begin
              state  <= S_DATA;
              sh     <= in_data;
              txd    <= in_data[1:0];
              di     <= 2'd0;
              bcnt   <= BCW'(1);
              last_q <= in_last;
            end else begin
              pcnt <= pcnt + PCW'(1);
              txd  <= ((pcnt + PCW'(1)) == SFD_IDX) ? 2'b11 : 2'b01;
            end
          end
          S_DATA, S_PAD: begin
            if (!byte_done) begin
              di  <= di + 2'd1;
              txd <= sh[3:2];
              sh  <= {2'b00, sh[7:2]};
            end else if (take) begin
              sh     <= in_data;
              txd    <= in_data[1:0];
              di     <= 2'd0;
              bcnt   <= bcnt + BCW'(1);
              last_q <= in_last;
            end else if (pad_next) begin
              state <= S_PAD;
              sh    <= 8'h00;
              txd   <= 2'b00;
              di    <= 2'd0;
              bcnt  <= bcnt + BCW'(1);
            end else begin
              state    <= S_FCS;
              sh       <= fcs_word[7:0];
              txd      <= fcs_word[1:0];
              fcs_rest <= fcs_word[31:8];
              fb       <= 2'd0;
              di       <= 2'd0;
            end
          end
          S_FCS: begin
            if (!byte_done) begin
              di  <= di + 2'd1;
              txd <= sh[3:2];
              sh  <= {2'b00, sh[7:2]};
            end else begin
              sh       <= fcs_rest[7:0];
              txd      <= fcs_rest[1:0];
              fcs_rest <= {8'h00, fcs_rest[23:8]};
              fb       <= fb + 2'd1;
              di       <= 2'd0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rmii_tx_10m_chk.sv
module rmii_tx_10m_chk #(
  parameter int CYC_PER_DIBIT = 10,
  parameter int GAP_CYCLES    = 480
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [1:0] txd,
  input logic       tx_en,
  input logic       err_underrun,
  input logic       err_oversize
);
  localparam int HW = (CYC_PER_DIBIT > 2) ? $clog2(CYC_PER_DIBIT) : 1;
  localparam int LW = $clog2(GAP_CYCLES + 1);
  localparam logic [HW-1:0] HLAST = HW'(CYC_PER_DIBIT - 1);
  localparam logic [LW-1:0] LSAT  = LW'(GAP_CYCLES);

  logic [HW-1:0] hc;
  logic [LW-1:0] lowc;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) hc <= '0;
    else hc <= (hc == HLAST) ? '0 : hc + HW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lowc <= LSAT;
    else if (tx_en) lowc <= '0;
    else if (lowc != LSAT) lowc <= lowc + LW'(1);
  end

  assert_idle_txd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 2'b00));

  assert_hold_dibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hc != '0) |-> (tx_en && $stable(txd)));

  assert_gap_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (lowc >= LSAT));

  assert_ready_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);

  assert_ready_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (hc == '0));

  assert_underrun_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |-> (!tx_en && $past(tx_en)));

  assert_oversize_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |-> (!tx_en && $past(tx_en)));

  assert_single_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_underrun, err_oversize}));
endmodule

bind rmii_tx_10m rmii_tx_10m_chk #(
  .CYC_PER_DIBIT(CYC_PER_DIBIT),
  .GAP_CYCLES(GAP_CYCLES)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_ready(in_ready),
  .txd(txd),
  .tx_en(tx_en),
  .err_underrun(err_underrun),
  .err_oversize(err_oversize)
);

// File: tb/rmii_tx_10m_test.sv
module rmii_tx_10m_test;
  localparam int CYC  = 3;
  localparam int GAP  = 40;
  localparam int MINB = 60;
  localparam int MAXB = 70;
  localparam int NF   = 16;
  localparam int ND   = 400;
  localparam logic [31:0] POLY = 32'hEDB8_8320;

  // {source length, seed, expected dibit count}
  localparam int NV = 6;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {12'd1,  8'h11, 12'd288},
    {12'd10, 8'h3C, 12'd288},
    {12'd59, 8'hA5, 12'd288},
    {12'd60, 8'h07, 12'd288},
    {12'd61, 8'hE2, 12'd292},
    {12'd66, 8'h90, 12'd312}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic in_ready;
  logic [1:0] txd;
  logic tx_en;
  logic err_underrun, err_oversize;

  always #5 clk = ~clk;

  rmii_tx_10m #(
    .CYC_PER_DIBIT(CYC), .PRE_DIBITS(31), .MIN_BYTES(MINB),
    .MAX_BYTES(MAXB), .GAP_CYCLES(GAP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .txd(txd), .tx_en(tx_en),
    .err_underrun(err_underrun), .err_oversize(err_oversize)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame records kept by the driver
  int nf = 0;
  int fn_len [NF];
  int fn_seed[NF];
  int fn_cut [NF];
  int fn_over[NF];
  int fn_gexp[NF];
  int fn_vexp[NF];

  // monitor records
  logic [1:0] dib [NF][ND];
  int nd  [NF];
  int rc  [NF];
  int eu  [NF];
  int eo  [NF];
  int gapv[NF];
  int fr = -1;
  int run = 0;
  int lowrun = 0;
  int holdbad = 0;
  int idlebad = 0;
  logic prev_en = 1'b0;
  logic [1:0] cur = 2'b00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (!prev_en) begin
          fr++;
          if (fr < NF) gapv[fr] = lowrun;
          lowrun = 0;
          run = 0;
        end
        if (run % CYC == 0) begin
          cur = txd;
          if (fr < NF && nd[fr] < ND) begin
            dib[fr][nd[fr]] = txd;
            nd[fr]++;
          end
        end else if (txd != cur) holdbad++;
        run++;
      end else begin
        if (prev_en && (run % CYC != 0)) holdbad++;
        if (txd != 2'b00 || in_ready) idlebad++;
        lowrun++;
      end
      if (fr >= 0 && fr < NF) begin
        if (in_ready) rc[fr]++;
        if (err_underrun) eu[fr]++;
        if (err_oversize) eo[fr]++;
      end
      prev_en = tx_en;
    end
  end

  function automatic logic [7:0] gb(input int sd, input int i);
    return 8'(sd * 13 + i * 29 + (i >> 3));
  endfunction

  task automatic send_frame(input int n, input int sd, input int cut, input int gexp, input int vexp);
    int f;
    bit aborted;
    bit got;
    f = nf;
    nf++;
    fn_len[f] = n; fn_seed[f] = sd; fn_cut[f] = cut; fn_gexp[f] = gexp;
    fn_vexp[f] = vexp; fn_over[f] = 0;
    aborted = 0;
    for (int i = 0; i < n; i++) begin
      if (cut >= 0 && i == cut) begin
        in_valid = 1'b0;
        do @(negedge clk); while (tx_en);
        return;
      end
      in_data  = gb(sd, i);
      in_last  = (i == n - 1);
      in_valid = 1'b1;
      got = 0;
      while (!got && !aborted) begin
        @(negedge clk);
        if (err_oversize) aborted = 1;
        else if (in_ready) got = 1;
      end
      if (aborted) break;
      @(posedge clk);
      #1;
    end
    fn_over[f] = aborted ? 1 : 0;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (tx_en);
    repeat (60) @(negedge clk);
  endtask

  task automatic verify_frame(input int f);
    logic [7:0] eb [ND];
    int nb, m, ne, expnd, bpre, bdat, bpad, bfcs, exprc;
    logic [31:0] c;
    if (fn_over[f] != 0) nb = MAXB - 4;
    else if (fn_cut[f] >= 0) nb = fn_cut[f];
    else nb = fn_len[f];
    m = nb;
    for (int i = 0; i < nb; i++) eb[i] = gb(fn_seed[f], i);
    if (fn_over[f] == 0 && fn_cut[f] < 0) begin
      while (m < MINB) begin eb[m] = 8'h00; m++; end
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < m; i++)
        for (int k = 0; k < 8; k++) begin
          logic fbk;
          fbk = c[0] ^ eb[i][k];
          c = c >> 1;
          if (fbk) c = c ^ POLY;
        end
      c = ~c;
      for (int i = 0; i < 4; i++) eb[m + i] = c[8*i +: 8];
      ne = m + 4;
    end else ne = m;
    expnd = 32 + 4 * ne;
    if (fn_vexp[f] > 0) expnd = fn_vexp[f];
    chk(nd[f] == expnd, $sformatf("R7 frame %0d dibit count", f), nd[f], expnd);
    bpre = 0; bdat = 0; bpad = 0; bfcs = 0;
    for (int k = 0; k < 32; k++)
      if (dib[f][k] != ((k == 31) ? 2'b11 : 2'b01)) bpre++;
    for (int i = 0; i < ne; i++)
      for (int d = 0; d < 4; d++)
        if (32 + 4 * i + d < ND && dib[f][32 + 4 * i + d] != eb[i][2*d +: 2]) begin
          if (i < nb) bdat++;
          else if (i < m) bpad++;
          else bfcs++;
        end
    chk(bpre == 0, $sformatf("R2 frame %0d preamble mismatches", f), bpre, 0);
    chk(bdat == 0, $sformatf("R4 frame %0d data dibit mismatches", f), bdat, 0);
    if (m > nb) chk(bpad == 0, $sformatf("R5 frame %0d pad mismatches", f), bpad, 0);
    if (ne > m) chk(bfcs == 0, $sformatf("R6 frame %0d fcs mismatches", f), bfcs, 0);
    if (fn_over[f] != 0) exprc = MAXB - 4;
    else if (fn_cut[f] >= 0) exprc = fn_cut[f] + 1;
    else exprc = fn_len[f];
    chk(rc[f] == exprc, $sformatf("R9 frame %0d ready pulses", f), rc[f], exprc);
    chk(eu[f] == ((fn_cut[f] >= 0) ? 1 : 0), $sformatf("R10 frame %0d underrun pulses", f),
        eu[f], (fn_cut[f] >= 0) ? 1 : 0);
    chk(eo[f] == fn_over[f], $sformatf("R11 frame %0d oversize pulses", f), eo[f], fn_over[f]);
    if (fn_gexp[f] == 1)
      chk(gapv[f] == GAP, $sformatf("R8 frame %0d gap exact", f), gapv[f], GAP);
    else if (fn_gexp[f] == 2)
      chk(gapv[f] >= GAP, $sformatf("R8 frame %0d gap minimum", f), gapv[f], GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      nd[f] = 0; rc[f] = 0; eu[f] = 0; eo[f] = 0; gapv[f] = 0;
    end
    repeat (5) @(posedge clk);
    #1;
    chk(tx_en == 1'b0, "R1 reset tx_en", int'(tx_en), 0);
    chk(txd == 2'b00, "R1 reset txd", int'(txd), 0);
    chk(in_ready == 1'b0, "R1 reset in_ready", int'(in_ready), 0);
    chk({err_underrun, err_oversize} == 2'b00, "R1 reset errors",
        int'({err_underrun, err_oversize}), 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(tx_en == 1'b0, "R1 no start without valid", int'(tx_en), 0);

    // table-driven back-to-back frames
    for (int v = 0; v < NV; v++)
      send_frame(int'(VEC[v][31:20]), int'(VEC[v][19:12]), -1, (v > 0) ? 1 : 0,
                 int'(VEC[v][11:0]));
    wait_idle();

    // R10: source drops valid after three bytes
    send_frame(5, 8'h5A, 3, 2, 0);
    wait_idle();

    // R11: source offers more than the limit; next frame waits on the gap
    send_frame(80, 8'hC3, -1, 2, 0);
    send_frame(20, 8'h77, -1, 1, 0);
    wait_idle();

    chk(fr + 1 == nf, "R2 frames started", fr + 1, nf);
    for (int f = 0; f < nf; f++) verify_frame(f);
    chk(holdbad == 0, "R3 dibit hold violations", holdbad, 0);
    chk(idlebad == 0, "R1 idle line violations", idlebad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule